// File: doc/BRIEF.md
# Integer Register Renamer with Zeroing-Idiom Detection

This block is the rename stage of an out-of-order integer core. Each cycle it may accept one decoded micro-op. That micro-op names up to two architectural source registers and at most one architectural destination, drawn from sixteen integer registers. A mapping table holds the physical tag that currently stands for each architectural register.

Sources are translated through the mapping table. A destination takes a fresh physical tag from a free list, and the tag it displaces is reported with the micro-op. When that instruction retires, the displaced tag comes back through a commit port and returns to the free list. Because every write gets a new tag, write-after-write and write-after-read hazards disappear, and later readers see only the newest producer.

Some micro-ops clear a register by combining it with itself, through exclusive-or or subtraction. The stage recognises these and flags both source operands as carrying no dependency, so the micro-op can issue at once instead of waiting for the old value. It still receives a fresh destination tag. Renamed results appear on registered outputs one cycle after acceptance.

Top module: `rn_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, and the physical tags from 16 to PHYS_REGS-1 are free.
- R2: A source operand is reported with the tag most recently given to its architectural register, and its dependency flag is 1 unless the micro-op is a zeroing idiom.
- R3: Free tags are handed out in the order in which they became free: first 16, 17, 18 and so on in ascending order after reset, then committed tags in commit order. A tag in use is never handed out.
- R4: For a micro-op that writes a register, out_prev_tag carries the tag that register held just before the write.
- R5: A micro-op with in_op = 1 (exclusive-or) or in_op = 2 (subtraction), with both sources enabled and naming the same register, is a zeroing idiom. For it, out_zero_idiom is 1, both source dependency flags are 0, and its destination still receives a fresh tag.
- R6: A micro-op whose two sources are the same register but whose in_op is 0 or 3, or an exclusive-or or subtraction on two different registers, is not an idiom. Its dependency flags follow its source enables.
- R7: A micro-op with in_dst_en = 0 takes no tag from the free list and leaves the mapping table unchanged.
- R8: When the free list is empty, in_ready is 0 for a micro-op that writes a register and nothing is accepted. A micro-op without a destination is still accepted.
- R9: A tag returned with commit_valid goes to the back of the free list, and a stall caused by an empty list clears once the tag is present.
- R10: out_valid is 1 in exactly the cycle after a micro-op is accepted (in_valid and in_ready both 1), and 0 otherwise, including after reset.
- R11: When a micro-op reads and writes the same register, the source sees the mapping from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A micro-op is offered |
| in_ready | output | 1 | The offered micro-op can be accepted this cycle |
| in_op | input | 2 | Operation class: 0 general, 1 exclusive-or, 2 subtraction, 3 other |
| in_src1_en | input | 1 | First source is used |
| in_src1 | input | 4 | First source architectural register |
| in_src2_en | input | 1 | Second source is used |
| in_src2 | input | 4 | Second source architectural register |
| in_dst_en | input | 1 | Micro-op writes a destination |
| in_dst | input | 4 | Destination architectural register |
| commit_valid | input | 1 | A retiring instruction frees a tag |
| commit_tag | input | TAG_W | Tag returned to the free list |
| out_valid | output | 1 | Renamed micro-op present |
| out_zero_idiom | output | 1 | Micro-op was recognised as a zeroing idiom |
| out_src1_dep | output | 1 | First source waits on a producer |
| out_src1_tag | output | TAG_W | First source physical tag |
| out_src2_dep | output | 1 | Second source waits on a producer |
| out_src2_tag | output | TAG_W | Second source physical tag |
| out_dst_en | output | 1 | Renamed micro-op has a destination |
| out_dst_tag | output | TAG_W | Fresh destination tag |
| out_prev_tag | output | TAG_W | Tag displaced from the destination register |

## Verification
The bench keeps its own copy of the mapping table and of the free-tag queue, and predicts every tag. It first reads untouched registers, which tests the identity mapping at reset. Chains of writes and reads on one register separate the newest producer from stale ones. A micro-op that reads and writes the same register tests ordering within a single cycle. Exclusive-or and subtraction on one register are set against the same operations on two registers and against a general op with matching sources, which tests that the idiom match depends on both the operation and the register equality. Draining the free list, then issuing micro-ops with and without destinations, then committing a tag, tests the stall and its release, and checks that uops without a destination consume no tag.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int NUM_AREG = 16;
    localparam int AREG_W   = $clog2(NUM_AREG);

    typedef logic [AREG_W-1:0] areg_t;

    typedef enum logic [1:0] {
        OP_GEN = 2'd0,
        OP_XOR = 2'd1,
        OP_SUB = 2'd2,
        OP_OTH = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e op;
        logic     s1_en;
        areg_t    s1;
        logic     s2_en;
        areg_t    s2;
        logic     d_en;
        areg_t    d;
    } uop_arch_t;

    // Self-cancelling operation: result is zero whatever the register held.
    function automatic logic is_zero_idiom(input uop_arch_t u);
        return ((u.op == OP_XOR) || (u.op == OP_SUB)) &&
               u.s1_en && u.s2_en && (u.s1 == u.s2);
    endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int PHYS_REGS = 32,
    parameter int ARCH_REGS = 16,
    parameter int TAG_W     = $clog2(PHYS_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    output logic [TAG_W-1:0] pop_tag,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic             empty
);
    localparam int DEPTH = PHYS_REGS - ARCH_REGS;
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] slots [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_tag = slots[rd_ptr];
    assign empty   = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= TAG_W'(ARCH_REGS + i);
            end
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(DEPTH);
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_tag;
                wr_ptr        <= step(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (count != CW'(DEPTH)));

endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
    parameter int NUM_AREG = 16,
    parameter int TAG_W    = 5,
    parameter int NRD      = 3,
    parameter int AW       = $clog2(NUM_AREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NRD-1:0][AW-1:0]    rd_arch,
    output logic [NRD-1:0][TAG_W-1:0] rd_tag,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_arch,
    input  logic [TAG_W-1:0]          wr_tag
);
    logic [TAG_W-1:0] map [NUM_AREG];

    // Reads see the table as it stood before this cycle's write.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_tag[g] = map[rd_arch[g]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_AREG; i++) begin
                map[i] <= TAG_W'(i);
            end
        end else if (wr_en) begin
            map[wr_arch] <= wr_tag;
        end
    end

    p_map_update_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (map[$past(wr_arch)] == $past(wr_tag)));

endmodule

// File: rtl/rn_zero_detect.sv
module rn_zero_detect
    import rn_pkg::*;
(
    input  uop_arch_t uop,
    output logic      zero_idiom,
    output logic      s1_dep,
    output logic      s2_dep
);
    always_comb begin
        zero_idiom = is_zero_idiom(uop);
        s1_dep     = uop.s1_en && !zero_idiom;
        s2_dep     = uop.s2_en && !zero_idiom;
    end
endmodule

// File: rtl/rn_renamer.sv
module rn_renamer
    import rn_pkg::*;
#(
    parameter int PHYS_REGS = 32,
    parameter int TAG_W     = $clog2(PHYS_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_op,
    input  logic             in_src1_en,
    input  logic [3:0]       in_src1,
    input  logic             in_src2_en,
    input  logic [3:0]       in_src2,
    input  logic             in_dst_en,
    input  logic [3:0]       in_dst,
    input  logic             commit_valid,
    input  logic [TAG_W-1:0] commit_tag,
    output logic             out_valid,
    output logic             out_zero_idiom,
    output logic             out_src1_dep,
    output logic [TAG_W-1:0] out_src1_tag,
    output logic             out_src2_dep,
    output logic [TAG_W-1:0] out_src2_tag,
    output logic             out_dst_en,
    output logic [TAG_W-1:0] out_dst_tag,
    output logic [TAG_W-1:0] out_prev_tag
);
    localparam int NRD = 3;

    uop_arch_t uop;
    logic      fl_empty, accept, take_tag;
    logic      zi, d1, d2;
    logic [TAG_W-1:0]               fresh_tag;
    logic [NRD-1:0][AREG_W-1:0]     rd_arch;
    logic [NRD-1:0][TAG_W-1:0]      rd_tag;

    always_comb begin
        uop.op    = op_kind_e'(in_op);
        uop.s1_en = in_src1_en;
        uop.s1    = in_src1;
        uop.s2_en = in_src2_en;
        uop.s2    = in_src2;
        uop.d_en  = in_dst_en;
        uop.d     = in_dst;
    end

    assign in_ready = !(uop.d_en && fl_empty);
    assign accept   = in_valid && in_ready;
    assign take_tag = accept && uop.d_en;
    assign rd_arch  = {uop.d, uop.s2, uop.s1};

    rn_zero_detect u_zd (
        .uop        (uop),
        .zero_idiom (zi),
        .s1_dep     (d1),
        .s2_dep     (d2)
    );

    rn_free_list #(
        .PHYS_REGS (PHYS_REGS),
        .ARCH_REGS (NUM_AREG),
        .TAG_W     (TAG_W)
    ) u_fl (
        .clk      (clk),
        .rst      (rst),
        .pop      (take_tag),
        .pop_tag  (fresh_tag),
        .push     (commit_valid),
        .push_tag (commit_tag),
        .empty    (fl_empty)
    );

    rn_alias_table #(
        .NUM_AREG (NUM_AREG),
        .TAG_W    (TAG_W),
        .NRD      (NRD)
    ) u_rat (
        .clk     (clk),
        .rst     (rst),
        .rd_arch (rd_arch),
        .rd_tag  (rd_tag),
        .wr_en   (take_tag),
        .wr_arch (uop.d),
        .wr_tag  (fresh_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_zero_idiom <= 1'b0;
            out_src1_dep   <= 1'b0;
            out_src1_tag   <= '0;
            out_src2_dep   <= 1'b0;
            out_src2_tag   <= '0;
            out_dst_en     <= 1'b0;
            out_dst_tag    <= '0;
            out_prev_tag   <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_zero_idiom <= zi;
                out_src1_dep   <= d1;
                out_src1_tag   <= rd_tag[0];
                out_src2_dep   <= d2;
                out_src2_tag   <= rd_tag[1];
                out_dst_en     <= uop.d_en;
                out_dst_tag    <= uop.d_en ? fresh_tag : '0;
                out_prev_tag   <= uop.d_en ? rd_tag[2] : '0;
            end
        end
    end

    p_valid_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    p_idle_no_valid_r10: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);

    p_stall_no_take_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dst_en && fl_empty) |=> !out_valid);

    p_idiom_free_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_zero_idiom) |-> (!out_src1_dep && !out_src2_dep && out_dst_en));

    p_fresh_tag_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dst_en) |-> (out_dst_tag != out_prev_tag));

endmodule

// File: tb/rn_renamer_test.sv
module rn_renamer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PHYS = 32;
    localparam int TW   = $clog2(PHYS);

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready;
    logic [1:0] in_op;
    logic in_src1_en, in_src2_en, in_dst_en;
    logic [3:0] in_src1, in_src2, in_dst;
    logic commit_valid;
    logic [TW-1:0] commit_tag;
    logic out_valid, out_zero_idiom, out_src1_dep, out_src2_dep, out_dst_en;
    logic [TW-1:0] out_src1_tag, out_src2_tag, out_dst_tag, out_prev_tag;

    int n_chk = 0;
    int n_bad = 0;
    int ref_map [16];
    int ref_q [$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rn_renamer #(.PHYS_REGS(PHYS)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_src1_en(in_src1_en), .in_src1(in_src1),
        .in_src2_en(in_src2_en), .in_src2(in_src2),
        .in_dst_en(in_dst_en), .in_dst(in_dst),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .out_valid(out_valid), .out_zero_idiom(out_zero_idiom),
        .out_src1_dep(out_src1_dep), .out_src1_tag(out_src1_tag),
        .out_src2_dep(out_src2_dep), .out_src2_tag(out_src2_tag),
        .out_dst_en(out_dst_en), .out_dst_tag(out_dst_tag),
        .out_prev_tag(out_prev_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one micro-op, check the registered result, update the model.
    task automatic do_uop(input int op, input bit s1e, input int s1,
                          input bit s2e, input int s2, input bit de, input int d,
                          input string req);
        bit zi;
        int e1, e2, ed, ep;
        zi = ((op == 1) || (op == 2)) && s1e && s2e && (s1 == s2);
        e1 = ref_map[s1];
        e2 = ref_map[s2];
        ed = de ? ref_q[0] : 0;
        ep = de ? ref_map[d] : 0;
        in_valid = 1; in_op = 2'(op);
        in_src1_en = s1e; in_src1 = 4'(s1);
        in_src2_en = s2e; in_src2 = 4'(s2);
        in_dst_en = de; in_dst = 4'(d);
        @(posedge clk); @(negedge clk);
        in_valid = 0;
        chk(out_valid == 1, {req, " out_valid R10"}, out_valid, 1);
        chk(out_zero_idiom == zi, {req, " idiom"}, out_zero_idiom, zi);
        chk(out_src1_dep == (s1e && !zi), {req, " src1 dep"}, out_src1_dep, s1e && !zi);
        chk(out_src2_dep == (s2e && !zi), {req, " src2 dep"}, out_src2_dep, s2e && !zi);
        if (s1e && !zi) chk(out_src1_tag == e1, {req, " src1 tag R2"}, out_src1_tag, e1);
        if (s2e && !zi) chk(out_src2_tag == e2, {req, " src2 tag R2"}, out_src2_tag, e2);
        chk(out_dst_en == de, {req, " dst_en"}, out_dst_en, de);
        if (de) begin
            chk(out_dst_tag == ed, {req, " dst tag R3"}, out_dst_tag, ed);
            chk(out_prev_tag == ep, {req, " prev tag R4"}, out_prev_tag, ep);
            void'(ref_q.pop_front());
            ref_map[d] = ed;
        end
    endtask

    task automatic do_commit(input int t);
        commit_valid = 1; commit_tag = TW'(t);
        @(posedge clk); @(negedge clk);
        commit_valid = 0;
        ref_q.push_back(t);
    endtask

    task automatic t_reset;
        chk(out_valid == 0, "R10 reset out_valid", out_valid, 0);
        chk(in_ready == 1, "R1 reset ready", in_ready, 1);
        do_uop(0, 1, 3, 1, 12, 0, 0, "R1 identity 3/12");
        do_uop(3, 1, 0, 1, 15, 0, 0, "R1 identity 0/15");
    endtask

    task automatic t_chain;
        do_uop(0, 1, 2, 1, 3, 1, 1, "R3 first write r1");
        do_uop(0, 1, 1, 0, 0, 0, 0, "R2 read r1");
        do_uop(0, 1, 1, 1, 5, 1, 1, "R4 rewrite r1");
        do_uop(0, 1, 1, 1, 1, 1, 7, "R2 newest r1");
    endtask

    task automatic t_self_rw;
        do_uop(0, 1, 2, 1, 5, 1, 2, "R11 r2=r2+r5");
        do_uop(0, 1, 2, 0, 0, 0, 0, "R11 read r2 after");
    endtask

    task automatic t_idioms;
        do_uop(1, 1, 4, 1, 4, 1, 4, "R5 xor r4,r4");
        do_uop(0, 1, 4, 0, 0, 0, 0, "R5 read zeroed r4");
        do_uop(2, 1, 9, 1, 9, 1, 9, "R5 sub r9,r9");
        do_uop(1, 1, 4, 1, 5, 1, 6, "R6 xor distinct");
        do_uop(0, 1, 6, 1, 6, 1, 6, "R6 gen same src");
        do_uop(3, 1, 8, 1, 8, 1, 8, "R6 other same src");
        do_uop(2, 1, 10, 0, 10, 1, 10, "R6 sub one src");
    endtask

    task automatic t_nodst;
        int head;
        head = ref_q[0];
        do_uop(0, 1, 1, 1, 2, 0, 0, "R7 no dst");
        chk(ref_q[0] == head, "R7 model head", ref_q[0], head);
        do_uop(0, 1, 1, 0, 0, 1, 11, "R7 next takes head");
    endtask

    task automatic t_exhaust;
        int k = 0;
        while (ref_q.size() > 0) begin
            do_uop(0, 1, k % 16, 0, 0, 1, (k * 5) % 16, "R3 drain");
            k++;
        end
        in_valid = 1; in_op = 0; in_src1_en = 1; in_src1 = 3;
        in_src2_en = 0; in_dst_en = 1; in_dst = 3;
        #1;
        chk(in_ready == 0, "R8 stall ready", in_ready, 0);
        @(posedge clk); @(negedge clk);
        chk(out_valid == 0, "R8 stall no output", out_valid, 0);
        in_valid = 0;
        do_uop(0, 1, 3, 1, 4, 0, 0, "R8 no-dst while empty");
    endtask

    task automatic t_commit;
        int t;
        t = 1;
        do_commit(t);
        in_dst_en = 1;
        #1;
        chk(in_ready == 1, "R9 ready after commit", in_ready, 1);
        do_uop(0, 1, 0, 0, 0, 1, 12, "R9 reuse committed");
        do_commit(2);
        do_commit(4);
        do_uop(0, 1, 12, 1, 3, 1, 13, "R9 order a");
        do_uop(0, 1, 13, 1, 12, 1, 14, "R9 order b");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_op = 0;
        in_src1_en = 0; in_src1 = 0; in_src2_en = 0; in_src2 = 0;
        in_dst_en = 0; in_dst = 0; commit_valid = 0; commit_tag = '0;
        for (int i = 0; i < 16; i++) ref_map[i] = i;
        for (int i = 16; i < PHYS; i++) ref_q.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_chain();
        t_self_rw();
        t_idioms();
        t_nodst();
        t_exhaust();
        t_commit();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule